// File: doc/BRIEF.md
# Legacy Audio DMA Transfer-Length Controller

This block sets how many units a legacy audio DMA channel moves before it raises an interrupt, and what that channel presents to a downstream mixer. It holds a 16-bit base length and a 16-bit down-counter in one 32-bit register. A second register holds a control byte, a direct-playback data byte and a write-only test byte. A third register holds status.

Transferred units arrive on a valid/ready beat interface. `xfer_ready` is high only while the 3-bit command puts the channel in a counting mode. While ready is low, an upstream source must hold `xfer_valid` and its unit, and no beat is taken. Each accepted beat is one byte. In 16-bit mode, two beats make one counted word.

When the counter steps below zero, it reloads from the base length and issues a one-cycle interrupt. If looping is off, the command is then forced to pause. Mixer-side flags tell whether to fetch and mix, hold the last sample, or play the direct byte. The flags also tell whether the address counters advance.

Top module: `legacy_dma_length_ctrl`

## Requirements
- R1: After reset, all three registers read 0, the command is stop (000), `xfer_ready` is 0, and every mixer flag and `irq` are 0.
- R2: Register 0 holds the base length in bits 31:16 and the current count in bits 15:0. Each byte lane writes only when its bit in `reg_wr_be` is set. Register 1 holds the control byte in bits 7:0 and the direct byte in bits 15:8, and reads bits 31:16 as 0. Register 2 holds irq-pending in bit 0 and test-busy in bit 1.
- R3: When control bit 7 is 0 (byte mode), each accepted beat lowers the current count by one.
- R4: When control bit 7 is 1 (word mode), the count drops by one on every second accepted beat. A write to the current-count field restarts the pairing.
- R5: A decrement from a count of 0 loads the base length into the counter. `irq` is then high for exactly the one following cycle.
- R6: On that reload, if control bit 3 (loop) is 1 the command stays unchanged. If it is 0, the command becomes 101 (pause), unless software writes the control byte in the same cycle.
- R7: `xfer_ready` is 1 only for commands 001 (run), 010 (silent count) and 100 (silent address). For 000, 101, 111 and the reserved codes 011 and 110, the count never changes on a beat.
- R8: `mix_fetch` is 1 only in run. `mix_hold` is 1 only in pause. `mix_direct` is 1 only in 111, where `mix_direct_data` carries register-1 bits 15:8. Stop, both silent modes and the reserved codes drive no mixer flag.
- R9: `addr_count_en` is 1 in a cycle with an accepted beat, and only in run or silent-address mode.
- R10: The reload event sets a sticky irq-pending bit. Writing 1 to register-2 bit 0 clears it. A new event in the same cycle wins over the clear.
- R11: Writing byte lane 3 of register 1 stores that byte on `test_byte` and sets test-busy. `test_done` clears test-busy, and a new write in the same cycle wins.
- R12: A write to the current-count field in the same cycle as an accepted beat sets the written value, and no decrement or interrupt happens.
- R13: `fmt_16bit`, `fmt_stereo`, `fmt_signed`, `dir_record` and `loop_en` show control bits 7, 6, 5, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_be | input | 4 | Byte-lane enables for a write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data of the selected register (combinational) |
| xfer_valid | input | 1 | A transferred byte is offered |
| xfer_ready | output | 1 | Channel is counting and takes the beat |
| addr_count_en | output | 1 | Address counters advance this cycle |
| mix_fetch | output | 1 | Fetch and mix samples |
| mix_hold | output | 1 | Drive last loaded sample to mixer |
| mix_direct | output | 1 | Drive direct byte to mixer |
| mix_direct_data | output | 8 | Direct playback byte |
| fmt_16bit | output | 1 | 16-bit samples / word counting |
| fmt_stereo | output | 1 | Stereo samples |
| fmt_signed | output | 1 | Signed samples |
| dir_record | output | 1 | Recording direction |
| loop_en | output | 1 | Auto-reload continues transfer |
| irq | output | 1 | One-cycle block-end interrupt |
| irq_pending | output | 1 | Sticky interrupt flag |
| test_byte | output | 8 | Last written test byte |
| test_busy | output | 1 | Test byte awaiting delivery |
| test_done | input | 1 | Test byte delivered to memory |

## Verification
The assertions check these rules on every cycle:
- `irq` never lasts two cycles, and the pending bit is set whenever it is.
- No more than one mixer flag is high at a time.
- The address-count enable appears only with a completed handshake.
- The count never moves without an accepted beat or a write.
- A byte-mode beat from a nonzero count lowers the count by exactly one.

The reload value, the forced pause, the word pairing, write-over-decrement priority and the test-byte flag depend on chosen sequences and values. Only the bench's directed scenarios can show them.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 2;

  localparam logic [2:0] CMD_STOP     = 3'b000;
  localparam logic [2:0] CMD_RUN      = 3'b001;
  localparam logic [2:0] CMD_SIL_CNT  = 3'b010;
  localparam logic [2:0] CMD_SIL_ADDR = 3'b100;
  localparam logic [2:0] CMD_PAUSE    = 3'b101;
  localparam logic [2:0] CMD_DIRECT   = 3'b111;

  localparam logic [ADDR_W-1:0] RA_LEN    = 2'd0;
  localparam logic [ADDR_W-1:0] RA_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] RA_STATUS = 2'd2;

  typedef struct packed {
    logic counting;
    logic addr_mode;
    logic fetch;
    logic hold;
    logic direct;
  } mode_t;
endpackage

// File: rtl/ldma_cmd_decode.sv
module ldma_cmd_decode
  import ldma_pkg::*;
(
  input  logic [2:0] cmd,
  output mode_t      mode
);
  always_comb begin
    mode = '0;
    unique case (cmd)
      CMD_RUN: begin
        mode.counting  = 1'b1;
        mode.addr_mode = 1'b1;
        mode.fetch     = 1'b1;
      end
      CMD_SIL_CNT:  mode.counting = 1'b1;
      CMD_SIL_ADDR: begin
        mode.counting  = 1'b1;
        mode.addr_mode = 1'b1;
      end
      CMD_PAUSE:  mode.hold   = 1'b1;
      CMD_DIRECT: mode.direct = 1'b1;
      default:    mode = '0;
    endcase
  end
endmodule

// File: rtl/ldma_len_counter.sv
module ldma_len_counter #(
  parameter int unsigned LEN_W = 16,
  localparam int unsigned REG_W = 2 * LEN_W,
  localparam int unsigned NBYTE = REG_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NBYTE-1:0] wr_be,
  input  logic [REG_W-1:0] wr_data,
  input  logic             beat,
  input  logic             word_mode,
  output logic [LEN_W-1:0] base_q,
  output logic [LEN_W-1:0] cur_q,
  output logic             underflow
);
  localparam int unsigned CUR_BYTES = LEN_W / 8;

  logic [REG_W-1:0] merged;
  logic             cur_hit;
  logic             phase_q;
  logic             step;

  for (genvar gi = 0; gi < NBYTE; gi++) begin : g_lane
    assign merged[gi*8 +: 8] = (wr_en && wr_be[gi]) ? wr_data[gi*8 +: 8]
                                                     : ({base_q, cur_q} >> (gi*8));
  end

  assign cur_hit   = wr_en && (|wr_be[CUR_BYTES-1:0]);
  assign step      = beat && !cur_hit && (!word_mode || phase_q);
  assign underflow = step && (cur_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      cur_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      base_q <= merged[REG_W-1:LEN_W];
      if (cur_hit) begin
        cur_q   <= merged[LEN_W-1:0];
        phase_q <= 1'b0;
      end else begin
        if (beat && word_mode) phase_q <= !phase_q;
        if (underflow)  cur_q <= base_q;
        else if (step)  cur_q <= cur_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldma_ctrl_regs.sv
module ldma_ctrl_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic        stat_wr,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic        force_pause,
  input  logic        irq_evt,
  input  logic        test_done,
  output logic [7:0]  ctrl_q,
  output logic [7:0]  direct_q,
  output logic [7:0]  test_q,
  output logic        test_busy_q,
  output logic        pend_q,
  output logic        irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      direct_q    <= '0;
      test_q      <= '0;
      test_busy_q <= 1'b0;
      pend_q      <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= irq_evt;
      if (ctrl_wr && wr_be[0]) ctrl_q <= wr_data[7:0];
      else if (force_pause)    ctrl_q[2:0] <= ldma_pkg::CMD_PAUSE;
      if (ctrl_wr && wr_be[1]) direct_q <= wr_data[15:8];
      if (ctrl_wr && wr_be[3]) begin
        test_q      <= wr_data[31:24];
        test_busy_q <= 1'b1;
      end else if (test_done) begin
        test_busy_q <= 1'b0;
      end
      if (irq_evt) pend_q <= 1'b1;
      else if (stat_wr && wr_be[0] && wr_data[0]) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/legacy_dma_length_ctrl.sv
module legacy_dma_length_ctrl
  import ldma_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr_en,
  input  logic [3:0]  reg_wr_be,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  input  logic        xfer_valid,
  output logic        xfer_ready,
  output logic        addr_count_en,
  output logic        mix_fetch,
  output logic        mix_hold,
  output logic        mix_direct,
  output logic [7:0]  mix_direct_data,
  output logic        fmt_16bit,
  output logic        fmt_stereo,
  output logic        fmt_signed,
  output logic        dir_record,
  output logic        loop_en,
  output logic        irq,
  output logic        irq_pending,
  input  logic        test_done,
  output logic [7:0]  test_byte,
  output logic        test_busy
);
  logic [LEN_W-1:0] base_q, cur_q;
  logic [7:0]       ctrl_q, direct_q;
  logic             beat_acc, underflow;
  logic             len_wr, ctrl_wr, stat_wr;
  mode_t            mode;

  assign len_wr  = reg_wr_en && (reg_addr == RA_LEN);
  assign ctrl_wr = reg_wr_en && (reg_addr == RA_CTRL);
  assign stat_wr = reg_wr_en && (reg_addr == RA_STATUS);

  ldma_cmd_decode u_dec (.cmd(ctrl_q[2:0]), .mode(mode));

  assign xfer_ready = mode.counting;
  assign beat_acc   = xfer_valid && xfer_ready;

  ldma_len_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .wr_en(len_wr), .wr_be(reg_wr_be), .wr_data(reg_wr_data),
    .beat(beat_acc), .word_mode(ctrl_q[7]),
    .base_q(base_q), .cur_q(cur_q), .underflow(underflow)
  );

  ldma_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .stat_wr(stat_wr),
    .wr_be(reg_wr_be), .wr_data(reg_wr_data),
    .force_pause(underflow && !ctrl_q[3]),
    .irq_evt(underflow), .test_done(test_done),
    .ctrl_q(ctrl_q), .direct_q(direct_q), .test_q(test_byte),
    .test_busy_q(test_busy), .pend_q(irq_pending), .irq_q(irq)
  );

  assign addr_count_en   = beat_acc && mode.addr_mode;
  assign mix_fetch       = mode.fetch;
  assign mix_hold        = mode.hold;
  assign mix_direct      = mode.direct;
  assign mix_direct_data = direct_q;
  assign fmt_16bit       = ctrl_q[7];
  assign fmt_stereo      = ctrl_q[6];
  assign fmt_signed      = ctrl_q[5];
  assign dir_record      = ctrl_q[4];
  assign loop_en         = ctrl_q[3];

  always_comb begin
    unique case (reg_addr)
      RA_LEN:    reg_rd_data = {base_q, cur_q};
      RA_CTRL:   reg_rd_data = {16'h0, direct_q, ctrl_q};
      RA_STATUS: reg_rd_data = {30'h0, test_busy, irq_pending};
      default:   reg_rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ldma_len_checker.sv
module ldma_len_checker #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             irq_pending,
  input logic             mix_fetch,
  input logic             mix_hold,
  input logic             mix_direct,
  input logic             addr_count_en,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic             fmt_16bit,
  input logic             len_wr,
  input logic [3:0]       reg_wr_be,
  input logic [LEN_W-1:0] cur_q
);
  logic cur_wr;
  assign cur_wr = len_wr && (|reg_wr_be[1:0]);

  a_r5_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r10_pending_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_pending);
  a_r8_one_mix_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mix_fetch, mix_hold, mix_direct}));
  a_r9_addr_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
    addr_count_en |-> (xfer_valid && xfer_ready));
  a_r7_hold_without_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_valid && xfer_ready) && !cur_wr |=> $stable(cur_q));
  a_r3_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && !fmt_16bit && !cur_wr && cur_q != '0)
      |=> cur_q == $past(cur_q) - 1'b1);
endmodule

bind legacy_dma_length_ctrl ldma_len_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .irq_pending(irq_pending),
  .mix_fetch(mix_fetch), .mix_hold(mix_hold), .mix_direct(mix_direct),
  .addr_count_en(addr_count_en), .xfer_valid(xfer_valid),
  .xfer_ready(xfer_ready), .fmt_16bit(fmt_16bit), .len_wr(len_wr),
  .reg_wr_be(reg_wr_be), .cur_q(cur_q)
);

// File: tb/tb_legacy_dma_length_ctrl.sv
module tb_legacy_dma_length_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_be = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        xfer_valid = 1'b0;
  logic        xfer_ready, addr_count_en, mix_fetch, mix_hold, mix_direct;
  logic [7:0]  mix_direct_data, test_byte;
  logic        fmt_16bit, fmt_stereo, fmt_signed, dir_record, loop_en;
  logic        irq, irq_pending, test_busy;
  logic        test_done = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  legacy_dma_length_ctrl dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_be = be; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_be = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rd_data;
  endtask

  // one beat; returns irq after the edge and addr_count_en during the beat
  task automatic beat(output logic irq_after, output logic aen);
    @(negedge clk);
    xfer_valid = 1'b1;
    #1 aen = addr_count_en;
    @(negedge clk);
    xfer_valid = 1'b0;
    irq_after = irq;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 ready", xfer_ready, 0);
    chk("R1 mix", {mix_fetch, mix_hold, mix_direct, irq}, 0);
    rd(0, d); chk("R1 len", d, 0);
    rd(1, d); chk("R1 ctrl", d, 0);
    rd(2, d); chk("R1 status", d, 0);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    wr(0, 32'h1234_5678, 4'b1111);
    wr(0, 32'hAAAA_BBBB, 4'b0100);
    rd(0, d); chk("R2 byte lane", d, 32'h12AA_5678);
    wr(1, 32'hFFFF_0000, 4'b0100);
    rd(1, d); chk("R2 ctrl upper zero", d, 0);
  endtask

  task automatic t_loop_run();
    logic i, a;
    logic [31:0] d;
    wr(0, {16'd3, 16'd2}, 4'hF);
    wr(1, 32'h09, 4'h1);
    chk("R7 ready run", xfer_ready, 1);
    chk("R8 fetch run", {mix_fetch, mix_hold, mix_direct}, 3'b100);
    beat(i, a); chk("R9 addr in run", a, 1);
    rd(0, d); chk("R3 dec", d[15:0], 1);
    beat(i, a); beat(i, a);
    chk("R5 irq pulse", i, 1);
    @(negedge clk); chk("R5 irq one cycle", irq, 0);
    rd(0, d); chk("R5 reload", d[15:0], 3);
    rd(1, d); chk("R6 loop keeps run", d[7:0], 8'h09);
    chk("R10 pending", irq_pending, 1);
  endtask

  task automatic t_noloop();
    logic i, a;
    logic [31:0] d;
    wr(2, 1, 4'h1); chk("R10 clear", irq_pending, 0);
    wr(0, {16'd7, 16'd0}, 4'hF);
    wr(1, 32'h01, 4'h1);
    beat(i, a); chk("R5 irq noloop", i, 1);
    rd(1, d); chk("R6 forced pause", d[2:0], 3'b101);
    chk("R8 hold in pause", {mix_fetch, mix_hold, mix_direct}, 3'b010);
    chk("R7 ready pause", xfer_ready, 0);
    beat(i, a);
    rd(0, d); chk("R7 pause holds count", d[15:0], 7);
    wr(2, 1, 4'h1);
  endtask

  task automatic t_word();
    logic i, a;
    logic [31:0] d;
    wr(0, {16'd0, 16'd5}, 4'hF);
    wr(1, 32'h89, 4'h1);
    chk("R13 16bit", fmt_16bit, 1);
    beat(i, a); rd(0, d); chk("R4 first beat", d[15:0], 5);
    beat(i, a); rd(0, d); chk("R4 second beat", d[15:0], 4);
    beat(i, a); beat(i, a); rd(0, d); chk("R4 pair two", d[15:0], 3);
  endtask

  task automatic t_silent();
    logic i, a;
    logic [31:0] d;
    wr(0, {16'd0, 16'd4}, 4'hF);
    wr(1, 32'h0A, 4'h1);
    chk("R8 silent cnt flags", {mix_fetch, mix_hold, mix_direct}, 0);
    beat(i, a); chk("R9 no addr silent cnt", a, 0);
    rd(0, d); chk("R7 silent cnt counts", d[15:0], 3);
    wr(1, 32'h0C, 4'h1);
    beat(i, a); chk("R9 addr silent addr", a, 1);
    rd(0, d); chk("R7 silent addr counts", d[15:0], 2);
    chk("R8 silent addr flags", {mix_fetch, mix_hold, mix_direct}, 0);
  endtask

  task automatic t_idle_modes();
    logic i, a;
    logic [31:0] d;
    wr(0, {16'd1, 16'd0}, 4'hF);
    wr(1, 32'h0B, 4'h1);
    beat(i, a); rd(0, d); chk("R7 reserved 011", d[15:0], 0);
    chk("R7 no irq reserved", i, 0);
    wr(1, 32'h0E, 4'h1);
    beat(i, a); rd(0, d); chk("R7 reserved 110", d[15:0], 0);
    wr(1, 32'h08, 4'h1);
    beat(i, a); rd(0, d); chk("R7 stop holds", d[15:0], 0);
    chk("R10 no pend when stopped", irq_pending, 0);
    wr(1, 32'h5A0F, 4'h3);
    chk("R8 direct flags", {mix_fetch, mix_hold, mix_direct}, 3'b001);
    chk("R8 direct data", mix_direct_data, 8'h5A);
    beat(i, a); rd(0, d); chk("R7 direct holds", d[15:0], 0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(0, {16'd9, 16'd10}, 4'hF);
    wr(1, 32'h09, 4'h1);
    @(negedge clk);
    xfer_valid = 1'b1; reg_addr = 0; reg_wr_data = 32'h42;
    reg_wr_be = 4'b0011; reg_wr_en = 1'b1;
    @(negedge clk);
    xfer_valid = 1'b0; reg_wr_en = 1'b0; reg_wr_be = '0;
    rd(0, d); chk("R12 write wins", d[15:0], 16'h42);
    wr(0, 0, 4'b0011);
    @(negedge clk);
    xfer_valid = 1'b1; reg_wr_data = 32'h5; reg_wr_be = 4'b0001; reg_wr_en = 1'b1;
    @(negedge clk);
    xfer_valid = 1'b0; reg_wr_en = 1'b0; reg_wr_be = '0;
    chk("R12 no irq on write", irq, 0);
    rd(0, d); chk("R12 value at zero", d[15:0], 5);
  endtask

  task automatic t_test_byte();
    logic [31:0] d;
    wr(1, 32'hC300_0000, 4'b1000);
    chk("R11 byte", test_byte, 8'hC3);
    rd(2, d); chk("R11 busy", d[1], 1);
    @(negedge clk); test_done = 1'b1;
    @(negedge clk); test_done = 1'b0;
    chk("R11 cleared", test_busy, 0);
  endtask

  task automatic t_format();
    wr(1, 32'h70, 4'h1);
    chk("R13 flags", {fmt_16bit, fmt_stereo, fmt_signed, dir_record, loop_en}, 5'b01110);
  endtask

  initial begin
    #20 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_loop_run();
    t_noloop();
    t_word();
    t_silent();
    t_idle_modes();
    t_priority();
    t_test_byte();
    t_format();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule